// File: doc/BRIEF.md
# Latched-Address Flash Bus Sequencer

This block sits on the host side of a 16-bit asynchronous NOR-style flash device. It turns single-word read and write requests into strobe sequences on the device pins. The device takes its address in a phase of its own: chip enable goes low, the address is driven, and a latch-enable strobe captures the address on its rising edge. The data phase follows. For a read, output enable is pulsed low. For a write, write enable is pulsed low while the controller drives the data bus.

Every phase lasts a programmable number of clock cycles set by configuration inputs. These cover address setup, latch-enable low width, read wait, write-enable low width, data hold after write enable rises, recovery between cycles and reset pulse length. A value of zero is treated as one, so no strobe is ever shorter than a full clock. Between accesses the bus stays in standby: all strobes high and the data bus released. A reset request drives the active-low device reset for its programmed length and then returns to standby.

Top module: `flash_bus_seq`

## Requirements
- R1: After `rst`, `fl_ce_n`, `fl_oe_n`, `fl_we_n`, `fl_le_n` and `fl_rst_n` are all 1, `fl_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` high at a rising clock edge), `fl_ce_n` goes low and `fl_addr` carries the request address. `fl_le_n` stays high for `cfg_aset` cycles, then goes low for `cfg_le_low` cycles, then rises with `fl_ce_n` still low. `fl_addr` holds steady while `fl_ce_n` is low.
- R3: After the latch phase of a read (`req_write`=0), `fl_oe_n` is low for `cfg_rd_wait` cycles, with `fl_ce_n` low, `fl_we_n` and `fl_le_n` high and `fl_dq_oe` 0.
- R4: `fl_dq_i` is sampled in the last cycle that `fl_oe_n` is low. It appears on `rsp_rdata`, with `rsp_valid` high for exactly one cycle: the first cycle after `fl_oe_n` returns high.
- R5: After the latch phase of a write (`req_write`=1), `fl_we_n` is low for `cfg_we_low` cycles. During this time `fl_ce_n` is low, `fl_oe_n` and `fl_le_n` are high, `fl_dq_oe` is 1 and `fl_dq_o` equals the request data.
- R6: After `fl_we_n` rises, `fl_ce_n` stays low and the data stays driven for `cfg_wr_hold` cycles. Only then does `fl_ce_n` rise, so write enable always rises before chip enable.
- R7: `fl_dq_oe` is 1 only while `fl_oe_n` is 1.
- R8: After each access, all strobes are high and the data bus is released for `cfg_recover` cycles, with `req_ready` low. `req_ready` returns to 1 in the next cycle.
- R9: `rst_req` high while idle drives `fl_rst_n` low for `cfg_rst_len` cycles. During that time `req_ready` is 0 and the other strobes are high. The block then returns to the R1 standby state. `rst_req` takes priority over a simultaneous request.
- R10: Any timing input set to 0 gives a phase of exactly one cycle.
- R11: `fl_le_n` is never low while `fl_we_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_aset | input | CW | Cycles of address setup before latch enable falls |
| cfg_le_low | input | CW | Latch-enable low width in cycles |
| cfg_rd_wait | input | CW | Output-enable low width (read wait) in cycles |
| cfg_we_low | input | CW | Write-enable low width in cycles |
| cfg_wr_hold | input | CW | Data and chip-enable hold after write enable rises |
| cfg_recover | input | CW | Idle cycles after each access |
| cfg_rst_len | input | CW | Device reset pulse length in cycles |
| rst_req | input | 1 | Request a device reset pulse |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DW | Read data |
| fl_addr | output | AW | Device address lines |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_le_n | output | 1 | Address latch enable, active low |
| fl_rst_n | output | 1 | Device reset, active low |
| fl_dq_o | output | DW | Data driven toward the device |
| fl_dq_oe | output | 1 | Data bus drive enable (tri-state control) |
| fl_dq_i | input | DW | Data returned from the device |

## Verification
All strobes are registered with the phase state, so the first cycle of address setup is the cycle right after the accepting clock edge. Each later phase begins in the cycle after the previous one's count ends. The bench samples at the falling edge and steps through every expected phase cycle by cycle, comparing the full strobe vector against the programmed widths. The read model makes the returned word depend on how long output enable has been low, so `rsp_rdata` matches only if sampling happened in the last low cycle. `rsp_valid` is expected in the first recovery cycle, and `req_ready` exactly `cfg_recover` cycles after that.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RESET = 3'd1,
    PH_ASET  = 3'd2,
    PH_LATCH = 3'd3,
    PH_READ  = 3'd4,
    PH_WLOW  = 3'd5,
    PH_WHOLD = 3'd6,
    PH_RECOV = 3'd7
  } phase_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic le_n;
    logic dq_oe;
    logic rst_n;
  } pins_t;

  localparam pins_t PINS_STANDBY = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                     le_n: 1'b1, dq_oe: 1'b0, rst_n: 1'b1};

  function automatic pins_t pins_for(input phase_t ph);
    pins_t p;
    p = PINS_STANDBY;
    case (ph)
      PH_RESET: p.rst_n = 1'b0;
      PH_ASET:  p.ce_n  = 1'b0;
      PH_LATCH: begin p.ce_n = 1'b0; p.le_n = 1'b0; end
      PH_READ:  begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      PH_WLOW:  begin p.ce_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      PH_WHOLD: begin p.ce_n = 1'b0; p.dq_oe = 1'b1; end
      default:  p = PINS_STANDBY;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  // a length of zero behaves as one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (len == '0) ? '0 : len - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/flash_strobe_gen.sv
module flash_strobe_gen
  import flash_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t ph_nxt,
  output pins_t  pins
);
  pins_t pins_q;

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_STANDBY;
    else     pins_q <= pins_for(ph_nxt);
  end

  assign pins = pins_q;
endmodule

// File: rtl/flash_bus_seq.sv
module flash_bus_seq
  import flash_seq_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_aset,
  input  logic [CW-1:0] cfg_le_low,
  input  logic [CW-1:0] cfg_rd_wait,
  input  logic [CW-1:0] cfg_we_low,
  input  logic [CW-1:0] cfg_wr_hold,
  input  logic [CW-1:0] cfg_recover,
  input  logic [CW-1:0] cfg_rst_len,
  input  logic          rst_req,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] fl_addr,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic          fl_le_n,
  output logic          fl_rst_n,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i
);
  phase_t        ph_q, ph_nxt;
  logic          is_wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rsp_q;
  logic          ph_done;
  logic          ph_load;
  logic [CW-1:0] ph_len;
  logic          accept;
  pins_t         pins;

  assign req_ready = (ph_q == PH_IDLE) && !rst_req;
  assign accept    = req_valid && req_ready;

  always_comb begin
    ph_nxt = ph_q;
    case (ph_q)
      PH_IDLE: begin
        if (rst_req)        ph_nxt = PH_RESET;
        else if (req_valid) ph_nxt = PH_ASET;
      end
      PH_RESET: if (ph_done) ph_nxt = PH_IDLE;
      PH_ASET:  if (ph_done) ph_nxt = PH_LATCH;
      PH_LATCH: if (ph_done) ph_nxt = is_wr_q ? PH_WLOW : PH_READ;
      PH_READ:  if (ph_done) ph_nxt = PH_RECOV;
      PH_WLOW:  if (ph_done) ph_nxt = PH_WHOLD;
      PH_WHOLD: if (ph_done) ph_nxt = PH_RECOV;
      PH_RECOV: if (ph_done) ph_nxt = PH_IDLE;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (ph_nxt)
      PH_RESET: ph_len = cfg_rst_len;
      PH_ASET:  ph_len = cfg_aset;
      PH_LATCH: ph_len = cfg_le_low;
      PH_READ:  ph_len = cfg_rd_wait;
      PH_WLOW:  ph_len = cfg_we_low;
      PH_WHOLD: ph_len = cfg_wr_hold;
      PH_RECOV: ph_len = cfg_recover;
      default:  ph_len = '0;
    endcase
  end

  assign ph_load = (ph_nxt != ph_q);

  flash_phase_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (ph_load),
    .len  (ph_len),
    .done (ph_done)
  );

  flash_strobe_gen u_strobe (
    .clk    (clk),
    .rst    (rst),
    .ph_nxt (ph_nxt),
    .pins   (pins)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      ph_q  <= ph_nxt;
      rsp_q <= (ph_q == PH_READ) && ph_done;
      if (accept) begin
        is_wr_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if ((ph_q == PH_READ) && ph_done) rdata_q <= fl_dq_i;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign fl_addr   = addr_q;
  assign fl_dq_o   = wdata_q;
  assign fl_ce_n   = pins.ce_n;
  assign fl_oe_n   = pins.oe_n;
  assign fl_we_n   = pins.we_n;
  assign fl_le_n   = pins.le_n;
  assign fl_rst_n  = pins.rst_n;
  assign fl_dq_oe  = pins.dq_oe;
endmodule

// File: rtl/flash_bus_seq_chk.sv
module flash_bus_seq_chk #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] fl_addr,
  input logic          fl_ce_n,
  input logic          fl_oe_n,
  input logic          fl_we_n,
  input logic          fl_le_n,
  input logic          fl_rst_n,
  input logic [DW-1:0] fl_dq_o,
  input logic          fl_dq_oe
);
  // R7
  bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_oe_n);

  // R11
  le_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_le_n);

  // R5
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

  // R5
  wdata_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_dq_o));

  // R6
  we_before_ce_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_ce_n) |-> $past(fl_we_n));

  // R4
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4
  rsp_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (fl_oe_n && $past(!fl_oe_n)));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

  // R9
  reset_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_rst_n |-> (!req_ready && fl_ce_n));
endmodule

bind flash_bus_seq flash_bus_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .fl_addr   (fl_addr),
  .fl_ce_n   (fl_ce_n),
  .fl_oe_n   (fl_oe_n),
  .fl_we_n   (fl_we_n),
  .fl_le_n   (fl_le_n),
  .fl_rst_n  (fl_rst_n),
  .fl_dq_o   (fl_dq_o),
  .fl_dq_oe  (fl_dq_oe)
);

// File: tb/sim_flash_bus_seq.sv
module sim_flash_bus_seq;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_aset = 8'd1, cfg_le_low = 8'd1, cfg_rd_wait = 8'd1;
  logic [CW-1:0] cfg_we_low = 8'd1, cfg_wr_hold = 8'd1, cfg_recover = 8'd1;
  logic [CW-1:0] cfg_rst_len = 8'd1;
  logic rst_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata, fl_dq_o, fl_dq_i;
  logic [AW-1:0] fl_addr;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_le_n, fl_rst_n, fl_dq_oe;

  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;
  logic [DW-1:0] oe_cnt = '0;

  always #2 clk = ~clk;

  // device model: word depends on how long output enable has been low
  always @(posedge clk) oe_cnt <= fl_oe_n ? '0 : oe_cnt + 1'b1;
  assign fl_dq_i = fl_oe_n ? '0 : ((fl_addr[DW-1:0] ^ 16'h5A3C) + oe_cnt);

  flash_bus_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst),
    .cfg_aset(cfg_aset), .cfg_le_low(cfg_le_low), .cfg_rd_wait(cfg_rd_wait),
    .cfg_we_low(cfg_we_low), .cfg_wr_hold(cfg_wr_hold), .cfg_recover(cfg_recover),
    .cfg_rst_len(cfg_rst_len), .rst_req(rst_req),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_le_n(fl_le_n), .fl_rst_n(fl_rst_n), .fl_dq_o(fl_dq_o),
    .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  // strobe vector {ce_n, oe_n, we_n, le_n, dq_oe, rst_n, ready}
  function automatic logic [6:0] vec();
    return {fl_ce_n, fl_oe_n, fl_we_n, fl_le_n, fl_dq_oe, fl_rst_n, req_ready};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input logic [6:0] exp, input string tag);
    chk(vec() == exp, tag, {57'd0, vec()}, {57'd0, exp});
  endtask

  function automatic int eff(input logic [CW-1:0] v);
    return (v == '0) ? 1 : int'(v);
  endfunction

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic addr_phase(input logic [AW-1:0] a);
    for (int i = 0; i < eff(cfg_aset); i++) begin
      chk_vec(7'b0111010, "R2 setup strobes");
      chk(fl_addr == a, "R2 address", fl_addr, a);
      @(negedge clk);
    end
    for (int i = 0; i < eff(cfg_le_low); i++) begin
      chk_vec(7'b0110010, "R2 latch strobes");
      chk(fl_addr == a, "R2 address in latch", fl_addr, a);
      @(negedge clk);
    end
  endtask

  task automatic recover_phase();
    for (int i = 0; i < eff(cfg_recover); i++) begin
      if (i > 0) chk(rsp_valid == 1'b0, "R4 single pulse", rsp_valid, 0);
      chk_vec(7'b1111010, "R8 recovery");
      @(negedge clk);
    end
    chk_vec(7'b1111011, "R8 ready after recovery");
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    logic [DW-1:0] exp;
    exp = (a[DW-1:0] ^ 16'h5A3C) + DW'(eff(cfg_rd_wait) - 1);
    issue(1'b0, a, '0);
    addr_phase(a);
    for (int i = 0; i < eff(cfg_rd_wait); i++) begin
      chk_vec(7'b0011010, "R3 read strobes");
      chk(rsp_valid == 1'b0, "R4 no early valid", rsp_valid, 0);
      @(negedge clk);
    end
    chk(rsp_valid == 1'b1, "R4 valid after oe", rsp_valid, 1);
    chk(rsp_rdata == exp, "R4 read data", rsp_rdata, exp);
    recover_phase();
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    addr_phase(a);
    for (int i = 0; i < eff(cfg_we_low); i++) begin
      chk_vec(7'b0101110, "R5 write strobes");
      chk(fl_dq_o == d, "R5 write data", fl_dq_o, d);
      @(negedge clk);
    end
    for (int i = 0; i < eff(cfg_wr_hold); i++) begin
      chk_vec(7'b0111110, "R6 hold strobes");
      chk(fl_dq_o == d, "R6 held data", fl_dq_o, d);
      @(negedge clk);
    end
    recover_phase();
  endtask

  task automatic t_reset_pulse();
    @(negedge clk);
    rst_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 22'h3;
    @(negedge clk);
    rst_req = 1'b0;
    for (int i = 0; i < eff(cfg_rst_len); i++) begin
      chk_vec(7'b1111000, "R9 reset pulse");
      if (i == eff(cfg_rst_len) - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    chk_vec(7'b1111011, "R9 back to standby");
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_vec(7'b1111011, "R1 standby after reset");
    chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);

    cfg_aset = 8'd2; cfg_le_low = 8'd3; cfg_rd_wait = 8'd4; cfg_recover = 8'd2;
    t_read(22'h2ABCDE);
    cfg_aset = 8'd1; cfg_le_low = 8'd1; cfg_rd_wait = 8'd1; cfg_recover = 8'd1;
    t_read(22'h000001);
    cfg_aset = 8'd2; cfg_le_low = 8'd2; cfg_we_low = 8'd3; cfg_wr_hold = 8'd2;
    cfg_recover = 8'd3;
    t_write(22'h15A5A5, 16'hBEEF);
    // R10 zero timing values
    cfg_aset = 8'd0; cfg_le_low = 8'd0; cfg_we_low = 8'd0; cfg_wr_hold = 8'd0;
    cfg_recover = 8'd0; cfg_rd_wait = 8'd0;
    t_write(22'h3FFFFF, 16'h1234);
    t_read(22'h012345);
    cfg_rd_wait = 8'd6; cfg_recover = 8'd4;
    t_read(22'h2AAAAA);
    cfg_rst_len = 8'd5;
    t_reset_pulse();
    cfg_rst_len = 8'd0;
    t_reset_pulse();

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule